// File: doc/BRIEF.md
# Egress QoS Tag Rewriter

This block sits on the egress side of one switch port. For each outgoing frame it takes the classified QoS class, the drop-precedence level, and the frame's own DSCP, PCP and DEI values. It returns the DSCP, PCP and DEI values that the frame should carry when it leaves. Frame parsing and checksum repair are done elsewhere. The block only computes the three field values.

Software configures the block through a narrow write port. The configuration covers:
- a DSCP trust switch;
- a 32-entry classified-DSCP table, where each entry has its own active flag;
- a per-class PCP/DEI mapping table;
- a per-level drop-precedence-to-DE grouping.

A classified DSCP replaces the frame's own DSCP only when trust is on and the DSCP table holds at least one active entry. When a class has a valid mapping, PCP comes from that mapping. DEI then follows the DE grouping of the frame's drop-precedence level, inverted when the mapping's DEI bit is 0.

A two-state controller sequences the outputs.
- The states are `ST_IDLE` (no result pending) and `ST_EMIT` (a result is presented with `out_valid` high).
- The transitions are: `ST_IDLE -> ST_EMIT` on `in_valid`, `ST_EMIT -> ST_EMIT` on a back-to-back `in_valid`, `ST_EMIT -> ST_IDLE` when `in_valid` is low, and `ST_IDLE -> ST_IDLE` otherwise.

Top module: `egress_tag_rewriter`

## Requirements
- R1: After reset:
  - `out_valid` and all data outputs are 0.
  - DSCP trust is on and DSCP classification is therefore enabled.
  - No DSCP entry is active and no class mapping is valid.
  - The DE grouping is 4'b1110, so level 0 maps to DE0 and levels 1 to 3 map to DE1.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. Back-to-back inputs give back-to-back results.
- R3: When trust is on and any DSCP entry is active, `out_dscp` equals table entry number 8*`in_dp`+`in_class`. This holds even if that particular entry is not itself active.
- R4: When trust is off, `out_dscp` equals the frame's `in_dscp`.
- R5: When trust is on but no DSCP entry is active, `out_dscp` equals `in_dscp`.
- R6: For a class with a valid mapping, `out_pcp` is the mapping's PCP.
- R7: For a class with a valid mapping, the DEI output depends on the mapping's DEI bit.
  - If that bit is 1, `out_dei` is the DE grouping bit of `in_dp`.
  - If that bit is 0, `out_dei` is the inverse of that grouping bit.
- R8: For a class without a valid mapping, `out_pcp` and `out_dei` equal `in_pcp` and `in_dei`.
- R9: A configuration write takes effect on the cycle after it. A lookup in the same cycle as the write sees the old value.
- R10: The write port has a 6-bit `cfg_addr`, and the 7-bit `cfg_wdata` fields depend on the address:

  | Address | Target | `cfg_wdata` fields |
  |---|---|---|
  | 0..31 | DSCP entry whose index equals the address | [5:0] DSCP value, [6] active flag |
  | 32+c | mapping for class c | [2:0] PCP, [3] DEI, [4] valid |
  | 40 | control | [0] trust |
  | 41 | DE grouping | [3:0] one bit per drop-precedence level |
  | 42..63 | none | the write is ignored |

- R11: The data outputs hold their values in cycles that follow a cycle without `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 7 | Configuration write data |
| in_valid | input | 1 | Frame lookup request |
| in_class | input | 3 | Classified QoS class |
| in_dp | input | 2 | Drop-precedence level |
| in_dscp | input | 6 | Frame DSCP |
| in_pcp | input | 3 | Frame PCP |
| in_dei | input | 1 | Frame DEI |
| out_valid | output | 1 | Result strobe |
| out_dscp | output | 6 | Rewritten DSCP |
| out_pcp | output | 3 | Rewritten PCP |
| out_dei | output | 1 | Rewritten DEI |

## Verification
The bench targets the DSCP gating corner cases:
- A trusted port with an empty table must pass the frame DSCP. A design that tested only the trust switch would emit 0 there.
- An inactive entry looked up while another entry is active must return its own stored value. A design that gated per entry would pass the frame DSCP instead.

The bench also tests DEI polarity for mappings with DEI set and with DEI clear, both before and after the grouping is reprogrammed. A design that ignored the mapping's DEI bit would miss the inverted cases.

A write that collides with a lookup must return the old table value. A design with write-through lookup would return the new value a cycle early.

Writes to unused addresses must leave trust, tables and mappings unchanged, and outputs must hold while `in_valid` is low.

// File: rtl/qtr_pkg.sv
package qtr_pkg;

    typedef struct packed {
        logic       vld;
        logic       dei;
        logic [2:0] pcp;
    } pcp_map_t;

    localparam int MAP_W = $bits(pcp_map_t);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } qtr_state_e;

endpackage

// File: rtl/qtr_cfg_regs.sv
module qtr_cfg_regs
    import qtr_pkg::*;
#(
    parameter int              N_CLASS   = 8,
    parameter int              N_DP      = 4,
    parameter int              DSCP_W    = 6,
    parameter int              ADDR_W    = 6,
    parameter int              DATA_W    = 7,
    parameter logic            TRUST_RST = 1'b1,
    parameter logic [N_DP-1:0] GROUP_RST = 4'b1110
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [DATA_W-1:0]           cfg_wdata,
    output logic [N_CLASS*N_DP*DSCP_W-1:0] dscp_tbl_o,
    output logic                        any_active_o,
    output logic [N_CLASS*MAP_W-1:0]    pcp_map_o,
    output logic [N_CLASS-1:0]          map_vld_o,
    output logic                        trust_o,
    output logic [N_DP-1:0]             group_o
);
    localparam int N_ENT     = N_CLASS * N_DP;
    localparam int MAP_BASE  = N_ENT;
    localparam int CTRL_ADDR = MAP_BASE + N_CLASS;
    localparam int GRP_ADDR  = CTRL_ADDR + 1;

    logic [N_ENT-1:0] ent_active;

    // DSCP entries, one register slice per table index
    for (genvar e = 0; e < N_ENT; e++) begin : g_dscp
        localparam logic [ADDR_W-1:0] A = ADDR_W'(e);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dscp_tbl_o[e*DSCP_W +: DSCP_W] <= '0;
                ent_active[e]                  <= 1'b0;
            end else if (cfg_we && cfg_addr == A) begin
                dscp_tbl_o[e*DSCP_W +: DSCP_W] <= cfg_wdata[DSCP_W-1:0];
                ent_active[e]                  <= cfg_wdata[DSCP_W];
            end
        end
    end

    // per-class PCP/DEI mappings
    for (genvar c = 0; c < N_CLASS; c++) begin : g_map
        localparam logic [ADDR_W-1:0] A = ADDR_W'(MAP_BASE + c);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pcp_map_o[c*MAP_W +: MAP_W] <= '0;
            end else if (cfg_we && cfg_addr == A) begin
                pcp_map_o[c*MAP_W +: MAP_W] <= cfg_wdata[MAP_W-1:0];
            end
        end
        assign map_vld_o[c] = pcp_map_o[c*MAP_W + MAP_W - 1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trust_o <= TRUST_RST;
            group_o <= GROUP_RST;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_W'(CTRL_ADDR)) trust_o <= cfg_wdata[0];
            if (cfg_addr == ADDR_W'(GRP_ADDR))  group_o <= cfg_wdata[N_DP-1:0];
        end
    end

    assign any_active_o = |ent_active;

endmodule

// File: rtl/qtr_lookup.sv
module qtr_lookup
    import qtr_pkg::*;
#(
    parameter int N_CLASS = 8,
    parameter int N_DP    = 4,
    parameter int DSCP_W  = 6,
    parameter int CLS_W   = $clog2(N_CLASS),
    parameter int DP_W    = $clog2(N_DP)
) (
    input  logic [N_CLASS*N_DP*DSCP_W-1:0] dscp_tbl,
    input  logic                        any_active,
    input  logic [N_CLASS*MAP_W-1:0]    pcp_map,
    input  logic                        trust,
    input  logic [N_DP-1:0]             group,
    input  logic [CLS_W-1:0]            in_class,
    input  logic [DP_W-1:0]             in_dp,
    input  logic [DSCP_W-1:0]           in_dscp,
    input  logic [2:0]                  in_pcp,
    input  logic                        in_dei,
    output logic [DSCP_W-1:0]           nxt_dscp,
    output logic [2:0]                  nxt_pcp,
    output logic                        nxt_dei
);
    localparam int N_ENT = N_CLASS * N_DP;
    localparam int IDX_W = $clog2(N_ENT);

    logic [IDX_W-1:0]  idx;
    logic [DSCP_W-1:0] cls_dscp;
    pcp_map_t          m;
    logic              de_bit;

    always_comb begin
        idx      = IDX_W'(in_dp) * IDX_W'(N_CLASS) + IDX_W'(in_class);
        cls_dscp = dscp_tbl[idx*DSCP_W +: DSCP_W];
        nxt_dscp = (trust && any_active) ? cls_dscp : in_dscp;

        m        = pcp_map_t'(pcp_map[in_class*MAP_W +: MAP_W]);
        de_bit   = group[in_dp];
        if (m.vld) begin
            nxt_pcp = m.pcp;
            nxt_dei = m.dei ? de_bit : ~de_bit;
        end else begin
            nxt_pcp = in_pcp;
            nxt_dei = in_dei;
        end
    end

endmodule

// File: rtl/qtr_ctrl.sv
module qtr_ctrl
    import qtr_pkg::*;
#(
    parameter int DSCP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DSCP_W-1:0] nxt_dscp,
    input  logic [2:0]        nxt_pcp,
    input  logic              nxt_dei,
    output logic              out_valid,
    output logic [DSCP_W-1:0] out_dscp,
    output logic [2:0]        out_pcp,
    output logic              out_dei
);
    qtr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dscp <= '0;
            out_pcp  <= '0;
            out_dei  <= 1'b0;
        end else if (in_valid) begin
            out_dscp <= nxt_dscp;
            out_pcp  <= nxt_pcp;
            out_dei  <= nxt_dei;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/egress_tag_rewriter.sv
module egress_tag_rewriter
    import qtr_pkg::*;
#(
    parameter int N_CLASS = 8,
    parameter int N_DP    = 4,
    parameter int DSCP_W  = 6,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 7,
    parameter int CLS_W   = $clog2(N_CLASS),
    parameter int DP_W    = $clog2(N_DP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              in_valid,
    input  logic [CLS_W-1:0]  in_class,
    input  logic [DP_W-1:0]   in_dp,
    input  logic [DSCP_W-1:0] in_dscp,
    input  logic [2:0]        in_pcp,
    input  logic              in_dei,
    output logic              out_valid,
    output logic [DSCP_W-1:0] out_dscp,
    output logic [2:0]        out_pcp,
    output logic              out_dei
);
    localparam int N_ENT = N_CLASS * N_DP;

    logic [N_ENT*DSCP_W-1:0]  dscp_tbl;
    logic                     any_active;
    logic [N_CLASS*MAP_W-1:0] pcp_map;
    logic [N_CLASS-1:0]       map_vld;
    logic                     trust;
    logic [N_DP-1:0]          group;
    logic [DSCP_W-1:0]        nxt_dscp;
    logic [2:0]               nxt_pcp;
    logic                     nxt_dei;

    qtr_cfg_regs #(
        .N_CLASS(N_CLASS), .N_DP(N_DP), .DSCP_W(DSCP_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dscp_tbl_o(dscp_tbl), .any_active_o(any_active),
        .pcp_map_o(pcp_map), .map_vld_o(map_vld),
        .trust_o(trust), .group_o(group)
    );

    qtr_lookup #(
        .N_CLASS(N_CLASS), .N_DP(N_DP), .DSCP_W(DSCP_W),
        .CLS_W(CLS_W), .DP_W(DP_W)
    ) u_lkp (
        .dscp_tbl(dscp_tbl), .any_active(any_active), .pcp_map(pcp_map),
        .trust(trust), .group(group),
        .in_class(in_class), .in_dp(in_dp), .in_dscp(in_dscp),
        .in_pcp(in_pcp), .in_dei(in_dei),
        .nxt_dscp(nxt_dscp), .nxt_pcp(nxt_pcp), .nxt_dei(nxt_dei)
    );

    qtr_ctrl #(.DSCP_W(DSCP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .nxt_dscp(nxt_dscp), .nxt_pcp(nxt_pcp), .nxt_dei(nxt_dei),
        .out_valid(out_valid), .out_dscp(out_dscp),
        .out_pcp(out_pcp), .out_dei(out_dei)
    );

endmodule

// File: rtl/qtr_checker.sv
module qtr_checker #(
    parameter int N_CLASS = 8,
    parameter int DSCP_W  = 6,
    parameter int CLS_W   = $clog2(N_CLASS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [CLS_W-1:0]   in_class,
    input logic [DSCP_W-1:0]  in_dscp,
    input logic [2:0]         in_pcp,
    input logic               in_dei,
    input logic               out_valid,
    input logic [DSCP_W-1:0]  out_dscp,
    input logic [2:0]         out_pcp,
    input logic               out_dei,
    input logic               trust,
    input logic               any_act,
    input logic [N_CLASS-1:0] map_vld
);
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_UNTRUSTED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !trust) |=> out_dscp == $past(in_dscp)); // R4
    AST_EMPTY_TABLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !any_act) |=> out_dscp == $past(in_dscp)); // R5
    AST_UNMAPPED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !map_vld[in_class]) |=>
            (out_pcp == $past(in_pcp) && out_dei == $past(in_dei))); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_dscp) && $stable(out_pcp) && $stable(out_dei))); // R11
endmodule

bind egress_tag_rewriter qtr_checker #(
    .N_CLASS(N_CLASS), .DSCP_W(DSCP_W), .CLS_W(CLS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_dscp(in_dscp), .in_pcp(in_pcp), .in_dei(in_dei),
    .out_valid(out_valid), .out_dscp(out_dscp), .out_pcp(out_pcp),
    .out_dei(out_dei), .trust(trust), .any_act(any_active), .map_vld(map_vld)
);

// File: tb/sim_egress_tag_rewriter.sv
`timescale 1ns/1ps
module sim_egress_tag_rewriter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [6:0] cfg_wdata = '0;
    logic       in_valid = 1'b0;
    logic [2:0] in_class = '0;
    logic [1:0] in_dp = '0;
    logic [5:0] in_dscp = '0;
    logic [2:0] in_pcp = '0;
    logic       in_dei = 1'b0;
    logic       out_valid;
    logic [5:0] out_dscp;
    logic [2:0] out_pcp;
    logic       out_dei;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    egress_tag_rewriter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_class(in_class),
        .in_dp(in_dp), .in_dscp(in_dscp), .in_pcp(in_pcp), .in_dei(in_dei),
        .out_valid(out_valid), .out_dscp(out_dscp), .out_pcp(out_pcp),
        .out_dei(out_dei)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [6:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one lookup; outputs sampled at the negedge after the capturing posedge
    task automatic lookup(input logic [2:0] c, input logic [1:0] dp,
                          input logic [5:0] ds, input logic [2:0] p, input logic de);
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_dp = dp;
        in_dscp = ds; in_pcp = p; in_dei = de;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_dscp", int'(out_dscp), 0);
        check("R1 out_pcp", int'(out_pcp), 0);
        lookup(3'd4, 2'd1, 6'd17, 3'd5, 1'b1);
        check("R1 R2 strobe", int'(out_valid), 1);
        check("R1 R5 empty table keeps dscp", int'(out_dscp), 17);
        check("R1 R8 unmapped pcp", int'(out_pcp), 5);
        check("R8 unmapped dei", int'(out_dei), 1);
    endtask

    task automatic t_dscp;
        cfg_write(6'd21, {1'b1, 6'h2A});
        cfg_write(6'd31, {1'b1, 6'h3F});
        lookup(3'd5, 2'd2, 6'd3, 3'd0, 1'b0);
        check("R3 entry 21", int'(out_dscp), 'h2A);
        lookup(3'd7, 2'd3, 6'd3, 3'd0, 1'b0);
        check("R3 entry 31", int'(out_dscp), 'h3F);
        lookup(3'd5, 2'd1, 6'd9, 3'd0, 1'b0);
        check("R3 inactive entry 13 still used", int'(out_dscp), 0);
    endtask

    task automatic t_untrusted;
        cfg_write(6'd40, 7'd0);
        lookup(3'd5, 2'd2, 6'd44, 3'd0, 1'b0);
        check("R4 untrusted keeps dscp", int'(out_dscp), 44);
        cfg_write(6'd40, 7'd1);
        lookup(3'd5, 2'd2, 6'd44, 3'd0, 1'b0);
        check("R4 trust restored", int'(out_dscp), 'h2A);
    endtask

    task automatic t_pcp;
        cfg_write(6'd33, 7'h1E); // class1: valid, dei=1, pcp=6
        cfg_write(6'd34, 7'h13); // class2: valid, dei=0, pcp=3
        lookup(3'd1, 2'd0, 6'd0, 3'd0, 1'b1);
        check("R6 class1 pcp", int'(out_pcp), 6);
        check("R7 dei1 dp0", int'(out_dei), 0);
        lookup(3'd1, 2'd3, 6'd0, 3'd0, 1'b0);
        check("R7 dei1 dp3", int'(out_dei), 1);
        lookup(3'd2, 2'd0, 6'd0, 3'd7, 1'b0);
        check("R6 class2 pcp", int'(out_pcp), 3);
        check("R7 dei0 dp0 inverted", int'(out_dei), 1);
        lookup(3'd2, 2'd2, 6'd0, 3'd7, 1'b1);
        check("R7 dei0 dp2 inverted", int'(out_dei), 0);
    endtask

    task automatic t_group;
        cfg_write(6'd41, 7'b0000001);
        lookup(3'd1, 2'd0, 6'd0, 3'd0, 1'b0);
        check("R10 group dp0", int'(out_dei), 1);
        lookup(3'd1, 2'd1, 6'd0, 3'd0, 1'b1);
        check("R10 group dp1", int'(out_dei), 0);
        cfg_write(6'd50, 7'h7F);
        cfg_write(6'd63, 7'h7F);
        lookup(3'd1, 2'd1, 6'd0, 3'd0, 1'b1);
        check("R10 unused addr pcp", int'(out_pcp), 6);
        check("R10 unused addr dei", int'(out_dei), 0);
        check("R10 unused addr dscp", int'(out_dscp), 0);
        lookup(3'd3, 2'd2, 6'd0, 3'd5, 1'b1);
        check("R10 unused addr class3 pcp", int'(out_pcp), 5);
        lookup(3'd5, 2'd2, 6'd1, 3'd0, 1'b0);
        check("R10 unused addr trust", int'(out_dscp), 'h2A);
    endtask

    task automatic t_collision;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'd21; cfg_wdata = {1'b1, 6'h11};
        in_valid = 1'b1; in_class = 3'd5; in_dp = 2'd2; in_dscp = 6'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R9 same-cycle old value", int'(out_dscp), 'h2A);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 next cycle new value", int'(out_dscp), 'h11);
    endtask

    task automatic t_stream;
        @(negedge clk);
        in_valid = 1'b1; in_class = 3'd7; in_dp = 2'd3;
        @(negedge clk);
        check("R2 first of pair", int'(out_valid), 1);
        check("R3 first of pair", int'(out_dscp), 'h3F);
        in_class = 3'd5; in_dp = 2'd2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second of pair", int'(out_valid), 1);
        check("R3 second of pair", int'(out_dscp), 'h11);
        in_class = 3'd7; in_dp = 2'd3; in_pcp = 3'd2; in_dei = 1'b0;
        @(negedge clk);
        check("R2 drops", int'(out_valid), 0);
        check("R11 dscp held", int'(out_dscp), 'h11);
        check("R11 pcp held", int'(out_pcp), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dscp();
        t_untrusted();
        t_pcp();
        t_group();
        t_collision();
        t_stream();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule